// File: doc/BRIEF.md
# I2C Indexed Block-Transfer Configuration Target

This block is an I2C target that exposes a bank of 8-bit configuration registers to a host on the two-wire bus. Every transfer is indexed. To write, the host sends a start index, then a byte count, then that many data bytes. Each data byte lands at the current index, and the index then steps up by one. To read, the host first sets the index with a short write. It then issues a repeated start and the read address. The target answers with a byte count taken from a programmable count register, followed by register contents from the index onward. This continues until the host declines a byte.

Both bus lines pass through a two-flop synchroniser before they reach the logic. SDA is driven open-drain through a single pull-low enable. On the register side, the block presents every register as a flat vector. It also gives a one-cycle strobe per register whenever that register is written. A fixed identity register, a read-only alarm bit and the count register are handled inside the block.

Top module: `i2cblk_top`

## Requirements
- R1: The address byte 0xD2 (write) and 0xD3 (read) are acknowledged (SDA pulled low in the ninth clock). Any other address byte is not acknowledged, and every byte after it is ignored and not acknowledged until the next start.
- R2: In a write, the byte after 0xD2 sets the index N and the next byte sets the count X. The following X data bytes are each acknowledged and stored at N, N+1, ... in order.
- R3: Data bytes beyond the count X are not acknowledged and leave the registers unchanged.
- R4: In a read (0xD2, index N, repeated start, 0xD3), the target first sends the value of register 8. It then sends the registers N, N+1, ... MSB first while the host acknowledges. After a host not-acknowledge, it releases SDA.
- R5: Register 8 resets to 0x06. A value written to it becomes the count byte of later reads.
- R6: Register 7 always reads 0x01 (revision 0 in bits 7:4, vendor 1 in bits 3:0). Writes to it are acknowledged but change nothing.
- R7: Bit 5 of register 10 always reads the level of the `wdog_alarm` input and is stored as 0. Writes to it have no effect. The other seven bits of register 10 are writable.
- R8: A stop condition inside a byte abandons that byte without storing it and returns the target to idle. A following full transfer works normally.
- R9: Each stored data byte raises exactly one bit of `cfg_wr_stb`, the bit of its index, for one cycle. This happens while the target is still acknowledging that byte, and `cfg_q` shows the new value afterwards.
- R10: The target changes its SDA drive only while the synchronised SCL is low.
- R11: Indexes at or above NUM_REGS (15 by default) are acknowledged on write but store nothing and raise no strobe. They read as 0x00.
- R12: After reset, `sda_oe` is 0 and `cfg_q` holds 0x01 in register 7, 0x06 in register 8 and 0x00 everywhere else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| wdog_alarm | input | 1 | Alarm level shown at register 10 bit 5 |
| cfg_q | output | NUM_REGS*8 | All registers, register k in bits 8k+7:8k |
| cfg_wr_stb | output | NUM_REGS | One-cycle write strobe per register |

## Verification
The register write and the acknowledge drive fall together. The strobe for a stored byte rises while the target is still pulling SDA low for that byte's acknowledge. A scoreboard queues the expected strobe index for every data byte the host sends and compares each strobe against the head of that queue. It also samples the acknowledge bit in the same ninth clock, so an ack without a write, or a write without an ack, is reported. The same overlap is probed at the count limit, at the fixed identity register and past the last register. In those places the acknowledge and the write must separate.

// File: rtl/i2cblk_pkg.sv
`timescale 1ns/1ps
package i2cblk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INDEX,
    ST_COUNT,
    ST_WDATA,
    ST_RDATA
  } xfer_st_t;

  typedef enum logic [1:0] {
    PH_RX,
    PH_ACKTX,
    PH_TX,
    PH_ACKRX
  } bit_ph_t;

  localparam int ID_IDX   = 7;
  localparam int BCNT_IDX = 8;
  localparam int WDOG_IDX = 10;
  localparam int WDOG_BIT = 5;

  // value each register takes in reset
  function automatic logic [7:0] reg_reset(input int idx);
    case (idx)
      ID_IDX:   reg_reset = 8'h01;
      BCNT_IDX: reg_reset = 8'h06;
      default:  reg_reset = 8'h00;
    endcase
  endfunction

  // bits a host write may change
  function automatic logic [7:0] reg_wmask(input int idx);
    case (idx)
      ID_IDX:   reg_wmask = 8'h00;
      WDOG_IDX: reg_wmask = ~(8'h01 << WDOG_BIT);
      default:  reg_wmask = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/i2cblk_sync.sv
`timescale 1ns/1ps
module i2cblk_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q[s] <= '1;
        else if (s == 0) pipe_q[s] <= d;
        else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/i2cblk_cond.sv
`timescale 1ns/1ps
module i2cblk_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_p_q, sda_p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl_s;
      sda_p_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p_q;
  assign scl_fall  = ~scl_s & scl_p_q;
  assign start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
  assign stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;
endmodule

// File: rtl/i2cblk_regbank.sv
`timescale 1ns/1ps
module i2cblk_regbank
  import i2cblk_pkg::*;
#(
  parameter int NUM_REGS = 15,
  parameter int IDX_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_req,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  input  logic                  wdog_alarm,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] cfg_q,
  output logic [NUM_REGS-1:0]   cfg_wr_stb
);
  logic [7:0] regq [NUM_REGS];
  logic [7:0] view [NUM_REGS];

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [7:0] RST_V = reg_reset(g);
      localparam logic [7:0] MASK  = reg_wmask(g);
      logic hit;
      assign hit = wr_req && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          regq[g]       <= RST_V;
          cfg_wr_stb[g] <= 1'b0;
        end else begin
          cfg_wr_stb[g] <= hit;
          if (hit) regq[g] <= (regq[g] & ~MASK) | (wr_data & MASK);
        end
      end

      if (g == WDOG_IDX) begin : g_alarm
        always_comb begin
          view[g]           = regq[g];
          view[g][WDOG_BIT] = wdog_alarm;
        end
      end else begin : g_plain
        assign view[g] = regq[g];
      end

      assign cfg_q[g*8 +: 8] = regq[g];
    end
  endgenerate

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = view[i];
    end
  end

  a_r9_stb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cfg_wr_stb));

endmodule

// File: rtl/i2cblk_xfer.sv
`timescale 1ns/1ps
module i2cblk_xfer
  import i2cblk_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 15,
  parameter int         IDX_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  input  logic [7:0]       bcnt,
  output logic             sda_oe,
  output logic             wr_req,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic [IDX_W-1:0] rd_idx
);
  localparam logic [IDX_W-1:0] IDX_ONE = 1;
  localparam logic [IDX_W-1:0] IDX_LIM = IDX_W'(NUM_REGS);
  localparam logic [7:0]       WR_BYTE = {DEV_ADDR, 1'b0};
  localparam logic [7:0]       RD_BYTE = {DEV_ADDR, 1'b1};

  xfer_st_t         st_q, st_d;
  bit_ph_t          ph_q, ph_d;
  logic [3:0]       cnt_q, cnt_d;
  logic [7:0]       sr_q, sr_d;
  logic [7:0]       txr_q, txr_d;
  logic [7:0]       rem_q, rem_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] wr_idx_q, wr_idx_d;
  logic [7:0]       wr_data_q, wr_data_d;
  logic             oe_q, oe_d;
  logic             wr_req_q, wr_req_d;
  logic             hack_q, hack_d;

  always_comb begin
    st_d      = st_q;
    ph_d      = ph_q;
    cnt_d     = cnt_q;
    sr_d      = sr_q;
    txr_d     = txr_q;
    rem_d     = rem_q;
    idx_d     = idx_q;
    wr_idx_d  = wr_idx_q;
    wr_data_d = wr_data_q;
    oe_d      = oe_q;
    wr_req_d  = 1'b0;
    hack_d    = hack_q;

    if (stop_det) begin
      st_d  = ST_IDLE;
      ph_d  = PH_RX;
      cnt_d = 4'd0;
      oe_d  = 1'b0;
    end else if (start_det) begin
      st_d  = ST_ADDR;
      ph_d  = PH_RX;
      cnt_d = 4'd0;
      oe_d  = 1'b0;
    end else if (st_q != ST_IDLE) begin
      case (ph_q)
        PH_RX: begin
          if (scl_rise && cnt_q < 4'd8) begin
            sr_d  = {sr_q[6:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            ph_d  = PH_ACKTX;
            cnt_d = 4'd0;
            case (st_q)
              ST_ADDR: begin
                if (sr_q == WR_BYTE) begin
                  oe_d = 1'b1;
                  st_d = ST_INDEX;
                end else if (sr_q == RD_BYTE) begin
                  oe_d = 1'b1;
                  st_d = ST_RDATA;
                end else begin
                  st_d = ST_IDLE;
                end
              end
              ST_INDEX: begin
                oe_d  = 1'b1;
                idx_d = sr_q;
                st_d  = ST_COUNT;
              end
              ST_COUNT: begin
                oe_d  = 1'b1;
                rem_d = sr_q;
                st_d  = ST_WDATA;
              end
              ST_WDATA: begin
                if (rem_q != 8'd0) begin
                  oe_d      = 1'b1;
                  rem_d     = rem_q - 8'd1;
                  idx_d     = idx_q + IDX_ONE;
                  wr_req_d  = (idx_q < IDX_LIM);
                  wr_idx_d  = idx_q;
                  wr_data_d = sr_q;
                end else begin
                  st_d = ST_IDLE;
                end
              end
              default: ;
            endcase
          end
        end
        PH_ACKTX: begin
          if (scl_fall) begin
            cnt_d = 4'd0;
            if (st_q == ST_RDATA) begin
              ph_d  = PH_TX;
              txr_d = bcnt;
              oe_d  = ~bcnt[7];
            end else begin
              ph_d = PH_RX;
              oe_d = 1'b0;
            end
          end
        end
        PH_TX: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              ph_d = PH_ACKRX;
              oe_d = 1'b0;
            end else begin
              txr_d = {txr_q[6:0], 1'b0};
              oe_d  = ~txr_q[6];
            end
          end
        end
        PH_ACKRX: begin
          if (scl_rise) begin
            hack_d = ~sda_s;
          end else if (scl_fall) begin
            if (hack_q) begin
              ph_d  = PH_TX;
              cnt_d = 4'd0;
              txr_d = rd_data;
              oe_d  = ~rd_data[7];
              idx_d = idx_q + IDX_ONE;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ph_q      <= PH_RX;
      cnt_q     <= 4'd0;
      sr_q      <= 8'h00;
      txr_q     <= 8'h00;
      rem_q     <= 8'h00;
      idx_q     <= '0;
      wr_idx_q  <= '0;
      wr_data_q <= 8'h00;
      oe_q      <= 1'b0;
      wr_req_q  <= 1'b0;
      hack_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      ph_q      <= ph_d;
      cnt_q     <= cnt_d;
      sr_q      <= sr_d;
      txr_q     <= txr_d;
      rem_q     <= rem_d;
      idx_q     <= idx_d;
      wr_idx_q  <= wr_idx_d;
      wr_data_q <= wr_data_d;
      oe_q      <= oe_d;
      wr_req_q  <= wr_req_d;
      hack_q    <= hack_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_req  = wr_req_q;
  assign wr_idx  = wr_idx_q;
  assign wr_data = wr_data_q;
  assign rd_idx  = idx_q;

  a_r10_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> !$past(scl_s));

  a_r4_release_for_host_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ACKRX && st_q == ST_RDATA) |-> !oe_q);

endmodule

// File: rtl/i2cblk_top.sv
`timescale 1ns/1ps
module i2cblk_top
  import i2cblk_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 15,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic                  wdog_alarm,
  output logic [NUM_REGS*8-1:0] cfg_q,
  output logic [NUM_REGS-1:0]   cfg_wr_stb
);
  localparam int IDX_W = 8;

  logic [1:0]       rst_pipe_q;
  logic             rst_n_i;
  logic [1:0]       bus_s;
  logic             scl_s, sda_s;
  logic             scl_rise, scl_fall, start_det, stop_det;
  logic             wr_req;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_byte;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  i2cblk_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_i),
    .d    ({scl_i, sda_i}),
    .q    (bus_s)
  );
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  i2cblk_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2cblk_xfer #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .rd_data  (rd_byte),
    .bcnt     (cfg_q[BCNT_IDX*8 +: 8]),
    .sda_oe   (sda_oe),
    .wr_req   (wr_req),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx)
  );

  i2cblk_regbank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wr_req    (wr_req),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx),
    .wdog_alarm(wdog_alarm),
    .rd_data   (rd_byte),
    .cfg_q     (cfg_q),
    .cfg_wr_stb(cfg_wr_stb)
  );

  a_r9_stb_with_ack: assert property (@(posedge clk) disable iff (!rst_n_i)
    (|cfg_wr_stb) |-> sda_oe);

  a_r6_id_reads_one: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_idx == IDX_W'(ID_IDX)) |-> (rd_byte == 8'h01));

  a_r7_alarm_visible: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_idx == IDX_W'(WDOG_IDX)) |-> (rd_byte[WDOG_BIT] == wdog_alarm));

endmodule

// File: tb/tb_i2cblk_top.sv
`timescale 1ns/1ps
module tb_i2cblk_top;
  localparam int NR = 15;
  localparam int Q  = 10;

  logic            clk, rst_n;
  logic            scl_h, sda_h, sda_line;
  logic            sda_oe, wdog_alarm;
  logic [NR*8-1:0] cfg_q;
  logic [NR-1:0]   cfg_wr_stb;

  int checks, errors, r10_viol;
  int   exp_stb[$];
  logic [7:0] exp_rd[$];
  logic prev_oe;
  bit   done;

  assign sda_line = sda_h & ~sda_oe;

  i2cblk_top dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line),
    .sda_oe(sda_oe), .wdog_alarm(wdog_alarm),
    .cfg_q(cfg_q), .cfg_wr_stb(cfg_wr_stb)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_h = 1'b1; scl_h = 1'b1; wq(); sda_h = 1'b0; wq(); scl_h = 1'b0; wq();
  endtask
  task automatic bus_rstart();
    sda_h = 1'b1; wq(); scl_h = 1'b1; wq(); sda_h = 1'b0; wq(); scl_h = 1'b0; wq();
  endtask
  task automatic bus_stop();
    sda_h = 1'b0; wq(); scl_h = 1'b1; wq(); sda_h = 1'b1; wq(); wq();
  endtask
  task automatic send_bit(input logic b);
    sda_h = b; wq(); scl_h = 1'b1; wq(); wq(); scl_h = 1'b0; wq();
  endtask

  task automatic tx_chk(input logic [7:0] b, input logic exp_ack, input string tag);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_h = 1'b1; wq(); scl_h = 1'b1; wq();
    a = ~sda_line;
    wq(); scl_h = 1'b0; wq();
    chk(tag, {7'd0, a}, {7'd0, exp_ack});
  endtask

  task automatic rx_chk(input logic host_ack, input string tag);
    logic [7:0] b, e;
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_h = 1'b1; wq(); b[i] = sda_line; wq(); scl_h = 1'b0;
    end
    wq(); sda_h = ~host_ack; wq(); scl_h = 1'b1; wq(); wq(); scl_h = 1'b0; wq(); sda_h = 1'b1;
    if (exp_rd.size() == 0) begin
      errors++; $display("FAIL %s: actual %02h expected none queued", tag, b);
    end else begin
      e = exp_rd.pop_front();
      chk(tag, b, e);
    end
  endtask

  function automatic logic [7:0] rbyte(input int k);
    return cfg_q[k*8 +: 8];
  endfunction

  // strobe scoreboard monitor (R9)
  always @(negedge clk) begin
    if (rst_n && cfg_wr_stb != '0) begin
      if (exp_stb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected strobe: actual %h expected none", cfg_wr_stb);
      end else begin
        int k;
        k = exp_stb.pop_front();
        checks++;
        if (cfg_wr_stb !== (NR'(1) << k)) begin
          errors++;
          $display("FAIL R9 strobe: actual %h expected %h", cfg_wr_stb, NR'(1) << k);
        end
      end
    end
  end

  // R10 monitor: drive must not change while the host holds SCL high
  always @(negedge clk) begin
    if (rst_n && sda_oe !== prev_oe && scl_h) r10_viol++;
    prev_oe = sda_oe;
  end

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    checks = 0; errors = 0; r10_viol = 0; done = 1'b0; prev_oe = 1'b0;
    scl_h = 1'b1; sda_h = 1'b1; wdog_alarm = 1'b0; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R12 reset state
    chk("R12 sda_oe", {7'd0, sda_oe}, 8'h00);
    for (int k = 0; k < NR; k++)
      chk("R12 reset byte", rbyte(k), (k == 7) ? 8'h01 : (k == 8) ? 8'h06 : 8'h00);
    chk("R5 count reset", rbyte(8), 8'h06);

    // R2 block write idx 2, count 3
    exp_stb.push_back(2); exp_stb.push_back(3); exp_stb.push_back(4);
    bus_start();
    tx_chk(8'hD2, 1'b1, "R1 write addr ack");
    tx_chk(8'h02, 1'b1, "R2 index ack");
    tx_chk(8'h03, 1'b1, "R2 count ack");
    tx_chk(8'hAA, 1'b1, "R2 data ack");
    tx_chk(8'h55, 1'b1, "R2 data ack");
    tx_chk(8'hC3, 1'b1, "R2 data ack");
    bus_stop();
    chk("R2 reg2", rbyte(2), 8'hAA);
    chk("R2 reg3", rbyte(3), 8'h55);
    chk("R9 reg4 visible", rbyte(4), 8'hC3);

    // R3 bytes beyond count
    exp_stb.push_back(5);
    bus_start();
    tx_chk(8'hD2, 1'b1, "R1"); tx_chk(8'h05, 1'b1, "R2"); tx_chk(8'h01, 1'b1, "R2");
    tx_chk(8'h11, 1'b1, "R3 within count");
    tx_chk(8'h22, 1'b0, "R3 beyond count nack");
    bus_stop();
    chk("R3 reg5", rbyte(5), 8'h11);
    chk("R3 reg6 untouched", rbyte(6), 8'h00);

    // R4 block read from idx 2
    exp_rd.push_back(8'h06); exp_rd.push_back(8'hAA);
    exp_rd.push_back(8'h55); exp_rd.push_back(8'hC3);
    bus_start();
    tx_chk(8'hD2, 1'b1, "R4"); tx_chk(8'h02, 1'b1, "R4");
    bus_rstart();
    tx_chk(8'hD3, 1'b1, "R1 read addr ack");
    rx_chk(1'b1, "R4 count byte"); rx_chk(1'b1, "R4 data");
    rx_chk(1'b1, "R4 data"); rx_chk(1'b0, "R4 last data");
    chk("R4 released after nack", {7'd0, sda_oe}, 8'h00);
    bus_stop();

    // R5 count register changes read count
    exp_stb.push_back(8);
    bus_start();
    tx_chk(8'hD2, 1'b1, "R5"); tx_chk(8'h08, 1'b1, "R5"); tx_chk(8'h01, 1'b1, "R5");
    tx_chk(8'h03, 1'b1, "R5 write count reg");
    bus_stop();
    exp_rd.push_back(8'h03); exp_rd.push_back(8'h11);
    bus_start();
    tx_chk(8'hD2, 1'b1, "R5"); tx_chk(8'h05, 1'b1, "R5");
    bus_rstart(); tx_chk(8'hD3, 1'b1, "R5");
    rx_chk(1'b1, "R5 new count"); rx_chk(1'b0, "R5 data");
    bus_stop();

    // R6 identity register
    exp_stb.push_back(7);
    bus_start();
    tx_chk(8'hD2, 1'b1, "R6"); tx_chk(8'h07, 1'b1, "R6"); tx_chk(8'h01, 1'b1, "R6");
    tx_chk(8'hFF, 1'b1, "R6 write acked");
    bus_stop();
    chk("R6 id unchanged", rbyte(7), 8'h01);
    exp_rd.push_back(8'h03); exp_rd.push_back(8'h01);
    bus_start();
    tx_chk(8'hD2, 1'b1, "R6"); tx_chk(8'h07, 1'b1, "R6");
    bus_rstart(); tx_chk(8'hD3, 1'b1, "R6");
    rx_chk(1'b1, "R6 count"); rx_chk(1'b0, "R6 id read");
    bus_stop();

    // R7 alarm bit
    wdog_alarm = 1'b1;
    exp_stb.push_back(10);
    bus_start();
    tx_chk(8'hD2, 1'b1, "R7"); tx_chk(8'h0A, 1'b1, "R7"); tx_chk(8'h01, 1'b1, "R7");
    tx_chk(8'hFF, 1'b1, "R7");
    bus_stop();
    chk("R7 stored bit5 zero", rbyte(10), 8'hDF);
    exp_rd.push_back(8'h03); exp_rd.push_back(8'hFF);
    bus_start();
    tx_chk(8'hD2, 1'b1, "R7"); tx_chk(8'h0A, 1'b1, "R7");
    bus_rstart(); tx_chk(8'hD3, 1'b1, "R7");
    rx_chk(1'b1, "R7 count"); rx_chk(1'b0, "R7 alarm high");
    bus_stop();
    wdog_alarm = 1'b0;
    exp_rd.push_back(8'h03); exp_rd.push_back(8'hDF);
    bus_start();
    tx_chk(8'hD2, 1'b1, "R7"); tx_chk(8'h0A, 1'b1, "R7");
    bus_rstart(); tx_chk(8'hD3, 1'b1, "R7");
    rx_chk(1'b1, "R7 count"); rx_chk(1'b0, "R7 alarm low");
    bus_stop();

    // R1 foreign address
    bus_start();
    tx_chk(8'hA0, 1'b0, "R1 foreign nack");
    tx_chk(8'h02, 1'b0, "R1 ignored byte");
    tx_chk(8'h01, 1'b0, "R1 ignored byte");
    bus_stop();
    chk("R1 reg2 intact", rbyte(2), 8'hAA);

    // R8 stop inside a data byte
    bus_start();
    tx_chk(8'hD2, 1'b1, "R8"); tx_chk(8'h04, 1'b1, "R8"); tx_chk(8'h02, 1'b1, "R8");
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    chk("R8 partial not stored", rbyte(4), 8'hC3);
    chk("R8 released", {7'd0, sda_oe}, 8'h00);
    exp_stb.push_back(4);
    bus_start();
    tx_chk(8'hD2, 1'b1, "R8"); tx_chk(8'h04, 1'b1, "R8"); tx_chk(8'h01, 1'b1, "R8");
    tx_chk(8'h5A, 1'b1, "R8 recover");
    bus_stop();
    chk("R8 recovered write", rbyte(4), 8'h5A);

    // R11 past the last register
    exp_stb.push_back(14);
    bus_start();
    tx_chk(8'hD2, 1'b1, "R11"); tx_chk(8'h0E, 1'b1, "R11"); tx_chk(8'h02, 1'b1, "R11");
    tx_chk(8'h9C, 1'b1, "R11 last reg");
    tx_chk(8'h77, 1'b1, "R11 out of range acked");
    bus_stop();
    chk("R11 reg14", rbyte(14), 8'h9C);
    exp_rd.push_back(8'h03); exp_rd.push_back(8'h9C); exp_rd.push_back(8'h00);
    bus_start();
    tx_chk(8'hD2, 1'b1, "R11"); tx_chk(8'h0E, 1'b1, "R11");
    bus_rstart(); tx_chk(8'hD3, 1'b1, "R11");
    rx_chk(1'b1, "R11 count"); rx_chk(1'b1, "R11 reg14");
    rx_chk(1'b0, "R11 out of range reads zero");
    bus_stop();

    repeat (20) @(negedge clk);
    chk("R9 strobe queue drained", 8'(exp_stb.size()), 8'h00);
    chk("R10 no drive change with SCL high", 8'(r10_viol), 8'h00);
    report();
  end
endmodule